// File: doc/BRIEF.md
# SQE Heartbeat Pulse Generator

This block sits in the collision path of a virtual PHY port that faces an external MAC. When the link runs at 10 Mb/s in half duplex, each transmission from the MAC is followed by a short heartbeat pulse. The MAC uses this pulse to confirm that its collision detection path works. A transmission ends on the falling edge of transmit-enable. After that edge the block waits a fixed number of clock cycles, then raises a heartbeat request for a fixed number of cycles. A downstream collision-output mux combines this request with the other collision sources.

Three things gate the pulse. It is produced only in 10 Mb/s half-duplex operation. A disable control suppresses it. While external-MAC loopback is active, the request is held low. Loopback on the switch side has no input here and so does not affect the pulse.

The delay and width parameters are clock-cycle counts. Both default to `CLK_MHZ` cycles, which is 1.0 µs at the given clock frequency. Choose them so that the delay lands in 0.6–1.6 µs and the width in 0.5–1.5 µs. All pins are plain control levels, so there is no streaming interface and no back-pressure.

Top module: `sqe_heartbeat_gen`

## Requirements
- R1: While `rst_n` is low, `hb_req` is 0. Any sequence that was pending or active is discarded, so no pulse follows the release of reset without a new falling edge of `tx_en`.
- R2: The trigger is a falling edge of `tx_en`, with the block armed and idle. Let E0 be the first rising clock edge that samples `tx_en` low. `hb_req` rises right after edge E0+`DELAY_CYC`.
- R3: Once risen, `hb_req` stays high for exactly `WIDTH_CYC` clock cycles and then returns to 0.
- R4: The block is armed only when `link_10m`=1 (meaning 10 Mb/s) and `half_dup`=1 (meaning half duplex). When a transmission ends in any other combination, no pulse follows. Leaving the armed combination also aborts a pending or active sequence on the next edge.
- R5: With `hb_off`=1, no pulse is produced. Setting `hb_off` during the delay aborts that pending heartbeat, even if it is cleared again before the delay would have expired.
- R6: While `mac_lpbk`=1, `hb_req` is 0.
- R7: If `tx_en` is sampled high during the delay, the pending heartbeat is cancelled. The next falling edge starts a new full delay.
- R8: If `tx_en` rises while the pulse is active, the pulse still completes its full width. A later falling edge of `tx_en` starts a new heartbeat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit-enable from the external MAC |
| link_10m | input | 1 | 1 = link speed is 10 Mb/s |
| half_dup | input | 1 | 1 = link runs in half duplex |
| hb_off | input | 1 | 1 = heartbeat generation disabled |
| mac_lpbk | input | 1 | 1 = external-MAC loopback active |
| hb_req | output | 1 | Heartbeat request toward the collision mux |

## Verification
The bench builds the block with `DELAY_CYC`=6 and `WIDTH_CYC`=4 instead of the 1 µs defaults. These short windows let every test follow a whole sequence cycle by cycle: the exact rising and falling cycle of the pulse, and the cycles around them. With them, the bench can place a `tx_en` reassertion deterministically inside the delay or inside the pulse. It can also toggle the disable control partway through the delay, which exercises the cancel and abort paths without long runs.

// File: rtl/sqe_hb_pkg.sv
package sqe_hb_pkg;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sqe_txen_edge.sv
module sqe_txen_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  output logic tx_fall
);
  logic tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= tx_en;
  end

  // end of transmission: high last cycle, low now
  assign tx_fall = tx_q & ~tx_en;
endmodule

// File: rtl/sqe_hb_qualify.sv
module sqe_hb_qualify (
  input  logic link_10m,
  input  logic half_dup,
  input  logic hb_off,
  output logic armed
);
  assign armed = link_10m & half_dup & ~hb_off;
endmodule

// File: rtl/sqe_hb_timer.sv
module sqe_hb_timer
  import sqe_hb_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 25,
  parameter int unsigned WIDTH_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic tx_en,
  input  logic tx_fall,
  output logic pulse_on
);
  localparam int unsigned MAX_CYC = max_u(DELAY_CYC, WIDTH_CYC);
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] WID_LAST = CNT_W'(WIDTH_CYC - 1);

  hb_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!armed) begin
      state_d = HB_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        HB_IDLE: begin
          if (tx_fall) begin
            state_d = HB_WAIT;
            cnt_d   = '0;
          end
        end
        HB_WAIT: begin
          if (tx_en) begin
            state_d = HB_IDLE;
            cnt_d   = '0;
          end else if (cnt_q == DLY_LAST) begin
            state_d = HB_PULSE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        HB_PULSE: begin
          if (cnt_q == WID_LAST) begin
            state_d = HB_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          state_d = HB_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= HB_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pulse_on = (state_q == HB_PULSE);
endmodule

// File: rtl/sqe_heartbeat_gen.sv
module sqe_heartbeat_gen #(
  parameter int unsigned CLK_MHZ   = 25,
  parameter int unsigned DELAY_CYC = CLK_MHZ,
  parameter int unsigned WIDTH_CYC = CLK_MHZ
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic link_10m,
  input  logic half_dup,
  input  logic hb_off,
  input  logic mac_lpbk,
  output logic hb_req
);
  logic tx_fall;
  logic armed;
  logic pulse_on;

  sqe_txen_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .tx_fall (tx_fall)
  );

  sqe_hb_qualify u_qual (
    .link_10m (link_10m),
    .half_dup (half_dup),
    .hb_off   (hb_off),
    .armed    (armed)
  );

  sqe_hb_timer #(
    .DELAY_CYC (DELAY_CYC),
    .WIDTH_CYC (WIDTH_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (armed),
    .tx_en    (tx_en),
    .tx_fall  (tx_fall),
    .pulse_on (pulse_on)
  );

  // external-MAC loopback keeps the heartbeat off the collision path
  assign hb_req = pulse_on & ~mac_lpbk;
endmodule

// File: rtl/sqe_hb_checker.sv
module sqe_hb_checker #(
  parameter int unsigned WIDTH_CYC = 25
) (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic link_10m,
  input logic half_dup,
  input logic hb_off,
  input logic mac_lpbk,
  input logic hb_req
);
  int unsigned hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n)      hi_run <= 0;
    else if (hb_req) hi_run <= hi_run + 1;
    else             hi_run <= 0;
  end

  always_comb begin
    if (!rst_n) p_reset_low_r1: assert (!hb_req || $isunknown(hb_req));
  end

  p_width_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hb_req |-> (hi_run < WIDTH_CYC));

  p_link_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_10m && half_dup) |=> !hb_req);

  p_disable_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hb_off |=> !hb_req);

  p_lpbk_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mac_lpbk |-> !hb_req);

  p_no_rise_from_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !hb_req && !mac_lpbk) |=> !hb_req);
endmodule

bind sqe_heartbeat_gen sqe_hb_checker #(.WIDTH_CYC(WIDTH_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_en    (tx_en),
  .link_10m (link_10m),
  .half_dup (half_dup),
  .hb_off   (hb_off),
  .mac_lpbk (mac_lpbk),
  .hb_req   (hb_req)
);

// File: tb/tb_sqe_heartbeat_gen.sv
`timescale 1ns/1ps
module tb_sqe_heartbeat_gen;
  localparam int D = 6;
  localparam int W = 4;
  localparam int WIN = D + W + 3;

  logic clk = 1'b0;
  logic rst_n, tx_en, link_10m, half_dup, hb_off, mac_lpbk;
  logic hb_req;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sqe_heartbeat_gen #(.CLK_MHZ(200), .DELAY_CYC(D), .WIDTH_CYC(W)) dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .link_10m(link_10m),
    .half_dup(half_dup), .hb_off(hb_off), .mac_lpbk(mac_lpbk), .hb_req(hb_req)
  );

  task automatic chk(input string req, input logic act, input logic exp, input int k);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: hb_req=%b expected=%b", req, k, act, exp);
    end
  endtask

  // called at the negedge where tx_en was just driven low
  task automatic watch(input string req, input bit exp_on, input int raise_at);
    for (int k = 1; k <= WIN; k++) begin
      @(negedge clk);
      chk(req, hb_req, (exp_on && k >= D + 1 && k <= D + W) ? 1'b1 : 1'b0, k);
      if (k == raise_at) tx_en = 1'b1;
    end
  endtask

  task automatic end_frame(input int len);
    @(negedge clk); tx_en = 1'b1;
    repeat (len) @(negedge clk);
    tx_en = 1'b0;
  endtask

  task automatic set_mode(input logic s, input logic h, input logic off, input logic lp);
    @(negedge clk);
    link_10m = s; half_dup = h; hb_off = off; mac_lpbk = lp;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tx_en = 1'b0; link_10m = 1'b1; half_dup = 1'b1; hb_off = 1'b0; mac_lpbk = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", hb_req, 1'b0, 0);
    tx_en = 1'b1; repeat (3) @(negedge clk);
    tx_en = 1'b0;
    for (int k = 1; k <= WIN; k++) begin
      @(negedge clk);
      chk("R1", hb_req, 1'b0, k);
    end
    tx_en = 1'b1; @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
    rst_n = 1'b0; tx_en = 1'b0; @(negedge clk);
    rst_n = 1'b1;
    for (int k = 1; k <= WIN; k++) begin
      @(negedge clk);
      chk("R1", hb_req, 1'b0, k);
    end
  endtask

  task automatic t_basic();
    set_mode(1, 1, 0, 0);
    end_frame(3);  watch("R2 R3 short frame", 1, 0);
    end_frame(12); watch("R2 R3 long frame", 1, 0);
    end_frame(1);  watch("R2 R3 one-cycle frame", 1, 0);
  endtask

  task automatic t_link();
    set_mode(0, 1, 0, 0); end_frame(4); watch("R4 100M half", 0, 0);
    set_mode(1, 0, 0, 0); end_frame(4); watch("R4 10M full", 0, 0);
    set_mode(0, 0, 0, 0); end_frame(4); watch("R4 100M full", 0, 0);
    set_mode(1, 1, 0, 0); end_frame(4);
    for (int k = 1; k <= WIN; k++) begin
      @(negedge clk);
      chk("R4 abort by duplex", hb_req, 1'b0, k);
      if (k == 3) half_dup = 1'b0;
      if (k == 4) half_dup = 1'b1;
    end
  endtask

  task automatic t_disable();
    set_mode(1, 1, 1, 0); end_frame(4); watch("R5 disabled", 0, 0);
    set_mode(1, 1, 0, 0); end_frame(4);
    for (int k = 1; k <= WIN; k++) begin
      @(negedge clk);
      chk("R5 abort mid-delay", hb_req, 1'b0, k);
      if (k == 2) hb_off = 1'b1;
      if (k == 3) hb_off = 1'b0;
    end
  endtask

  task automatic t_loop();
    set_mode(1, 1, 0, 1); end_frame(5); watch("R6 mac loopback", 0, 0);
    set_mode(1, 1, 0, 0); end_frame(5); watch("R6 loopback cleared", 1, 0);
  endtask

  task automatic t_cancel();
    set_mode(1, 1, 0, 0);
    end_frame(4); watch("R7 cancelled", 0, 3);
    tx_en = 1'b0;
    watch("R7 restart full delay", 1, 0);
  endtask

  task automatic t_tx_in_pulse();
    set_mode(1, 1, 0, 0);
    end_frame(4); watch("R8 pulse completes", 1, D + 2);
    tx_en = 1'b0;
    watch("R8 next heartbeat", 1, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_link();
    t_disable();
    t_loop();
    t_cancel();
    t_tx_in_pulse();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule